// File: doc/BRIEF.md
# Gate Enable Source Arbiter

This block decides, once per clock, whether each of six low-side gate outputs should be on. In normal operation a channel turns on when either its bit in the serial command register or its own parallel enable pin is high. When the override-mode pin is high, the block switches to PWM operation. Channels 0 and 1 then track one PWM pin, channels 4 and 5 track a second PWM pin, and channels 2 and 3 keep following only their own parallel pins. In override mode the serial bits and the remaining parallel pins are ignored.

Two global shutdown conditions, supply reset and over-voltage, pull every gate low at once. A channel whose over-current flag is raised does not stay fully on. It is given a single-clock on pulse once every 64 clocks for as long as its request remains on. The parallel pins, the two PWM pins and the override-mode pin are asynchronous to the block clock, so each passes through a two-flop synchronizer before use. The serial command register and the fault flags already sit in the block's clock domain.

Top module: `gate_src_arbiter`

## Requirements
- R1: With override mode low, gate_en[i] equals ser_cmd[i] OR par_en[i] for every channel i.
- R2: With override mode high, ser_cmd has no effect on any gate, and par_en bits 0, 1, 4 and 5 have no effect.
- R3: With override mode high, gate_en[0] and gate_en[1] both equal pwm_a, and gate_en[4] and gate_en[5] both equal pwm_b.
- R4: With override mode high, gate_en[2] equals par_en[2] and gate_en[3] equals par_en[3], each independently.
- R5: With override mode low, pwm_a and pwm_b have no effect on any gate.
- R6: While por_active is high, all six gate_en bits are 0 in the same cycle, with no clock edge needed.
- R7: While ovp_active is high, all six gate_en bits are 0 in the same cycle, with no clock edge needed.
- R8: While oc_flag[i] is high and channel i's request is on, gate_en[i] is high for exactly 1 clock in every 64, with pulses exactly 64 clocks apart. Channels whose flag is low are unaffected.
- R9: While oc_flag[i] is high and channel i's request is off, gate_en[i] stays 0.
- R10: A change on par_en, pwm_a, pwm_b or ovr_mode reaches gate_en on the 3rd rising edge after it is applied and not earlier. A change on ser_cmd or oc_flag takes effect on the 1st rising edge.
- R11: While rst_n is low, gate_en is 0 regardless of the request inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_cmd | input | 6 | Serial command register contents, one bit per channel, 1 = on |
| par_en | input | 6 | Asynchronous parallel enable pins, 1 = on |
| pwm_a | input | 1 | Asynchronous PWM pin for channels 0 and 1 in override mode |
| pwm_b | input | 1 | Asynchronous PWM pin for channels 4 and 5 in override mode |
| ovr_mode | input | 1 | Asynchronous mode select, 1 = PWM override operation |
| por_active | input | 1 | Supply reset condition, forces all gates low |
| ovp_active | input | 1 | Over-voltage condition, forces all gates low |
| oc_flag | input | 6 | Per-channel over-current flag, 1 = fault |
| gate_en | output | 6 | Gate enable level per channel, 1 = on |

## Verification
The shutdown inputs act combinationally on the outputs, so their effect is due in the same cycle. Serial bits and over-current flags arrive one rising edge later, through the output register. Pin inputs arrive three edges later: two synchronizer stages plus the output register. The scoreboard stamps every expected value with the cycle number at which it is due. The monitor compares at the falling edge of exactly that cycle. The latency checks also confirm that the old value is still present one cycle before the due cycle. Duty-cycle behaviour is measured by counting high samples across whole 64-cycle windows and by the spacing between pulses.

// File: rtl/gsa_pkg.sv
package gsa_pkg;

  localparam int unsigned GSA_NUM_CH      = 6;
  localparam int unsigned GSA_SYNC_STAGES = 2;
  localparam int unsigned GSA_DUTY_PERIOD = 64;

  typedef enum logic {
    MODE_NORMAL   = 1'b0,
    MODE_OVERRIDE = 1'b1
  } gsa_mode_e;

  typedef enum logic [1:0] {
    SRC_LOCAL = 2'd0,
    SRC_PWM_A = 2'd1,
    SRC_PWM_B = 2'd2
  } gsa_src_e;

  // Which override source drives a given channel, given the pair masks.
  function automatic gsa_src_e ovr_source(input logic mask_a_bit, input logic mask_b_bit);
    if (mask_a_bit)      return SRC_PWM_A;
    else if (mask_b_bit) return SRC_PWM_B;
    else                 return SRC_LOCAL;
  endfunction

endpackage

// File: rtl/gsa_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
module gsa_sync #(
  parameter int unsigned WIDTH  = 9,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] stg_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_comb stg_d[s] = d;
    end else begin : g_next
      always_comb stg_d[s] = stg_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_d[s];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/gsa_duty_gen.sv
// Free-running period counter; tick marks the one allowed cycle per period.
module gsa_duty_gen #(
  parameter int unsigned PERIOD = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign tick = (cnt_q == '0);

endmodule

// File: rtl/gsa_src_mux.sv
// Per-channel request selection between normal and override operation.
module gsa_src_mux
  import gsa_pkg::*;
#(
  parameter int unsigned     NUM_CH     = 6,
  parameter logic [NUM_CH-1:0] PWM_A_MASK = 6'b000011,
  parameter logic [NUM_CH-1:0] PWM_B_MASK = 6'b110000
) (
  input  gsa_mode_e          mode,
  input  logic [NUM_CH-1:0]  ser,
  input  logic [NUM_CH-1:0]  par,
  input  logic               pwm_a,
  input  logic               pwm_b,
  output logic [NUM_CH-1:0]  req
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam gsa_src_e OVR_SRC = ovr_source(PWM_A_MASK[c], PWM_B_MASK[c]);
    logic ovr_req;

    if (OVR_SRC == SRC_PWM_A) begin : g_a
      always_comb ovr_req = pwm_a;
    end else if (OVR_SRC == SRC_PWM_B) begin : g_b
      always_comb ovr_req = pwm_b;
    end else begin : g_loc
      always_comb ovr_req = par[c];
    end

    always_comb begin
      if (mode == MODE_OVERRIDE) req[c] = ovr_req;
      else                       req[c] = ser[c] | par[c];
    end
  end

endmodule

// File: rtl/gate_src_arbiter.sv
module gate_src_arbiter
  import gsa_pkg::*;
#(
  parameter int unsigned       NUM_CH      = GSA_NUM_CH,
  parameter int unsigned       SYNC_STAGES = GSA_SYNC_STAGES,
  parameter int unsigned       DUTY_PERIOD = GSA_DUTY_PERIOD,
  parameter logic [NUM_CH-1:0] PWM_A_MASK  = 6'b000011,
  parameter logic [NUM_CH-1:0] PWM_B_MASK  = 6'b110000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ser_cmd,
  input  logic [NUM_CH-1:0] par_en,
  input  logic              pwm_a,
  input  logic              pwm_b,
  input  logic              ovr_mode,
  input  logic              por_active,
  input  logic              ovp_active,
  input  logic [NUM_CH-1:0] oc_flag,
  output logic [NUM_CH-1:0] gate_en
);

  localparam int unsigned PIN_W = NUM_CH + 3;

  // Reset: asserted asynchronously, released on the clock.
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  logic irst_n;
  assign irst_n = rst_s2_q;

  // Pin synchronization.
  logic [PIN_W-1:0] pins_async;
  logic [PIN_W-1:0] pins_sync;
  assign pins_async = {ovr_mode, pwm_b, pwm_a, par_en};

  gsa_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (irst_n),
    .d     (pins_async),
    .q     (pins_sync)
  );

  gsa_mode_e         mode_s;
  logic [NUM_CH-1:0] par_s;
  logic              pwm_a_s, pwm_b_s;
  assign par_s   = pins_sync[NUM_CH-1:0];
  assign pwm_a_s = pins_sync[NUM_CH];
  assign pwm_b_s = pins_sync[NUM_CH+1];
  assign mode_s  = gsa_mode_e'(pins_sync[NUM_CH+2]);

  // Source selection.
  logic [NUM_CH-1:0] req;
  gsa_src_mux #(
    .NUM_CH     (NUM_CH),
    .PWM_A_MASK (PWM_A_MASK),
    .PWM_B_MASK (PWM_B_MASK)
  ) u_mux (
    .mode  (mode_s),
    .ser   (ser_cmd),
    .par   (par_s),
    .pwm_a (pwm_a_s),
    .pwm_b (pwm_b_s),
    .req   (req)
  );

  // Low duty cycle timing for faulted channels.
  logic duty_tick;
  gsa_duty_gen #(.PERIOD(DUTY_PERIOD)) u_duty (
    .clk   (clk),
    .rst_n (irst_n),
    .tick  (duty_tick)
  );

  // Gate register: next-state and register processes.
  logic [NUM_CH-1:0] gate_d, gate_q;
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      gate_d[c] = req[c] & (~oc_flag[c] | duty_tick);
    end
  end

  always_ff @(posedge clk or negedge irst_n) begin
    if (!irst_n) gate_q <= '0;
    else         gate_q <= gate_d;
  end

  // Global shutdown acts without waiting for a clock edge.
  logic shutdown;
  assign shutdown = por_active | ovp_active;
  assign gate_en  = gate_q & {NUM_CH{~shutdown}};

endmodule

// File: rtl/gsa_checker.sv
module gsa_checker #(
  parameter int unsigned NUM_CH = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] ser_cmd,
  input logic [NUM_CH-1:0] par_en,
  input logic              pwm_a,
  input logic              pwm_b,
  input logic              ovr_mode,
  input logic              por_active,
  input logic              ovp_active,
  input logic [NUM_CH-1:0] oc_flag,
  input logic [NUM_CH-1:0] gate_en
);

  // Cycles since reset release, saturating; pipelines are full once warm.
  logic [3:0] since_q;
  logic       warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_q <= '0;
    else if (since_q != 4'hF) since_q <= since_q + 1'b1;
  end
  assign warm = (since_q >= 4'd8);

  a_r6_por_all_low: assert property (@(posedge clk) disable iff (!rst_n)
    por_active |-> (gate_en == '0));

  a_r7_ovp_all_low: assert property (@(posedge clk) disable iff (!rst_n)
    ovp_active |-> (gate_en == '0));

  a_r11_reset_low: assert property (@(posedge clk)
    !rst_n |-> (gate_en == '0));

  a_r1_normal_or: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !por_active && !ovp_active && !$past(ovr_mode, 3) && ($past(oc_flag) == '0))
    |-> (gate_en == ($past(ser_cmd) | $past(par_en, 3))));

  a_r3_pwm_pairs: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !por_active && !ovp_active && $past(ovr_mode, 3) && ($past(oc_flag) == '0))
    |-> (gate_en[0] == $past(pwm_a, 3) && gate_en[1] == $past(pwm_a, 3) &&
         gate_en[4] == $past(pwm_b, 3) && gate_en[5] == $past(pwm_b, 3)));

  a_r4_mid_local: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !por_active && !ovp_active && $past(ovr_mode, 3) && ($past(oc_flag) == '0))
    |-> (gate_en[3:2] == $past(par_en[3:2], 3)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_oc
    a_r8_oc_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (oc_flag[c] && $past(oc_flag[c]) && gate_en[c]) |=> !gate_en[c]);
  end

endmodule

bind gate_src_arbiter gsa_checker #(.NUM_CH(NUM_CH)) u_gsa_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ser_cmd    (ser_cmd),
  .par_en     (par_en),
  .pwm_a      (pwm_a),
  .pwm_b      (pwm_b),
  .ovr_mode   (ovr_mode),
  .por_active (por_active),
  .ovp_active (ovp_active),
  .oc_flag    (oc_flag),
  .gate_en    (gate_en)
);

// File: tb/tb_gate_src_arbiter.sv
`timescale 1ns/1ps
module tb_gate_src_arbiter;

  logic       clk;
  logic       rst_n;
  logic [5:0] ser_cmd, par_en, oc_flag;
  logic       pwm_a, pwm_b, ovr_mode, por_active, ovp_active;
  logic [5:0] gate_en;

  int checks;
  int fails;
  int cyc;

  typedef struct {
    int         due;
    logic [5:0] exp;
    string      tag;
  } exp_item_t;

  exp_item_t sb_q[$];

  gate_src_arbiter dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_cmd    (ser_cmd),
    .par_en     (par_en),
    .pwm_a      (pwm_a),
    .pwm_b      (pwm_b),
    .ovr_mode   (ovr_mode),
    .por_active (por_active),
    .ovp_active (ovp_active),
    .oc_flag    (oc_flag),
    .gate_en    (gate_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Expected gate levels from the requirements (no over-current here).
  function automatic logic [5:0] model(input logic [5:0] s, input logic [5:0] p,
                                       input logic a, input logic b, input logic m,
                                       input logic sd);
    if (sd) return 6'b0;
    if (m)  return {b, b, p[3], p[2], a, a};
    return s | p;
  endfunction

  function automatic logic [5:0] model_now();
    return model(ser_cmd, par_en, pwm_a, pwm_b, ovr_mode, por_active | ovp_active);
  endfunction

  task automatic push_exp(input int lat, input logic [5:0] e, input string tag);
    exp_item_t it;
    it.due = cyc + lat;
    it.exp = e;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Driver: apply just after a rising edge, queue the result due 3 edges later.
  task automatic drive(input logic [5:0] s, input logic [5:0] p, input logic a,
                       input logic b, input logic m, input string tag);
    @(posedge clk); #1;
    ser_cmd = s; par_en = p; pwm_a = a; pwm_b = b; ovr_mode = m;
    push_exp(3, model_now(), tag);
    repeat (5) @(posedge clk);
  endtask

  // Monitor: compare at the falling edge of the due cycle.
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      exp_item_t it;
      it = sb_q.pop_front();
      if (it.due < cyc) chk({it.tag, " missed"}, 32'(cyc), 32'(it.due));
      else              chk(it.tag, 32'(gate_en), 32'(it.exp));
    end
  end

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cyc = 0; checks = 0; fails = 0;
    rst_n = 1'b0;
    ser_cmd = 6'h3F; par_en = 6'h3F; pwm_a = 1'b1; pwm_b = 1'b1; ovr_mode = 1'b0;
    por_active = 1'b0; ovp_active = 1'b0; oc_flag = 6'h00;
    repeat (4) @(posedge clk);
    @(negedge clk) chk("R11 gate low in reset", 32'(gate_en), 32'h0);
    ser_cmd = 6'h00; par_en = 6'h00; pwm_a = 1'b0; pwm_b = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (8) @(posedge clk);
    @(negedge clk) chk("R11 idle after reset", 32'(gate_en), 32'h0);

    // Normal operation
    drive(6'b101010, 6'b000000, 1'b0, 1'b0, 1'b0, "R1 serial only");
    drive(6'b000000, 6'b010101, 1'b0, 1'b0, 1'b0, "R1 parallel only");
    drive(6'b100001, 6'b000110, 1'b0, 1'b0, 1'b0, "R1 serial or parallel");
    drive(6'b001000, 6'b000010, 1'b1, 1'b1, 1'b0, "R5 pwm ignored in normal");
    drive(6'b000000, 6'b000000, 1'b1, 1'b0, 1'b0, "R5 pwm_a alone ignored");

    // Override operation
    drive(6'b111111, 6'b000000, 1'b0, 1'b0, 1'b1, "R2 serial ignored");
    drive(6'b000000, 6'b110011, 1'b0, 1'b0, 1'b1, "R2 outer parallel ignored");
    drive(6'b000000, 6'b000000, 1'b1, 1'b0, 1'b1, "R3 pwm_a drives ch0 ch1");
    drive(6'b000000, 6'b001100, 1'b0, 1'b1, 1'b1, "R3 R4 pwm_b and mid locals");
    drive(6'b111111, 6'b000100, 1'b1, 1'b1, 1'b1, "R4 ch2 independent");
    drive(6'b000000, 6'b001000, 1'b0, 1'b0, 1'b1, "R4 ch3 independent");

    // Shutdown conditions (combinational, due the same cycle)
    drive(6'b111111, 6'b000000, 1'b0, 1'b0, 1'b0, "R1 all on before shutdown");
    @(posedge clk); #1 por_active = 1'b1; push_exp(0, 6'h00, "R6 por forces low");
    repeat (3) @(posedge clk);
    #1 por_active = 1'b0; push_exp(0, 6'h3F, "R6 por release restores");
    repeat (3) @(posedge clk);
    #1 ovp_active = 1'b1; push_exp(0, 6'h00, "R7 ovp forces low");
    repeat (3) @(posedge clk);
    #1 ovp_active = 1'b0; push_exp(0, 6'h3F, "R7 ovp release restores");
    repeat (3) @(posedge clk);

    // Latency
    drive(6'b000000, 6'b000000, 1'b0, 1'b0, 1'b0, "R10 clear");
    @(posedge clk); #1 par_en = 6'b110000;
    push_exp(2, 6'b000000, "R10 parallel not early");
    push_exp(3, 6'b110000, "R10 parallel on third edge");
    repeat (5) @(posedge clk);
    #1 ser_cmd = 6'b000011;
    push_exp(0, 6'b110000, "R10 serial old value");
    push_exp(1, 6'b110011, "R10 serial on first edge");
    repeat (3) @(posedge clk);
    #1 ovr_mode = 1'b1;
    push_exp(2, 6'b110011, "R10 mode not early");
    push_exp(3, 6'b000000, "R10 mode on third edge");
    repeat (5) @(posedge clk);

    // Over-current low duty cycle
    drive(6'b000011, 6'b000000, 1'b0, 1'b0, 1'b0, "R1 duty setup");
    @(posedge clk); #1 oc_flag = 6'b000001;
    repeat (3) @(posedge clk);
    begin
      int hi0, hi1, first, second;
      hi0 = 0; hi1 = 0; first = -1; second = -1;
      for (int k = 0; k < 128; k++) begin
        @(negedge clk);
        if (gate_en[0]) begin
          hi0++;
          if (first < 0) first = k;
          else if (second < 0) second = k;
        end
        if (gate_en[1]) hi1++;
      end
      chk("R8 one pulse per 64 cycles", 32'(hi0), 32'd2);
      chk("R8 pulse spacing 64", 32'(second - first), 32'd64);
      chk("R8 unflagged channel stays on", 32'(hi1), 32'd128);
    end
    @(posedge clk); #1 ser_cmd = 6'b000000; oc_flag = 6'b111111;
    repeat (2) @(posedge clk);
    begin
      int hi;
      hi = 0;
      for (int k = 0; k < 64; k++) begin
        @(negedge clk);
        if (gate_en != 6'b0) hi++;
      end
      chk("R9 faulted channel with no request stays low", 32'(hi), 32'd0);
    end

    repeat (4) @(posedge clk);
    chk("scoreboard drained", 32'(sb_q.size()), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule